// File: doc/BRIEF.md
# USB Controller Clock-Freeze and Wakeup Controller

This block manages the clocks of a USB device controller and the path that brings the system back from sleep. Firmware can freeze the controller clock with one control bit. The CPU can ask for one of two sleep depths:

- **Idle** stops only the CPU clock.
- **Power-down** also stops the oscillator, which halts every clock.

The block produces three clock enables: one for the controller clock, one for the oscillator and one for the CPU clock. It also raises a CPU wake request and the USB interrupt line.

Activity on the USB bus arrives asynchronously. A flop that sets asynchronously captures it, so it is recorded even when no clock runs. A two-flop synchronizer then carries it into a sticky wakeup flag, which is cleared by writing 1. From power-down, this flag, when enabled, is the only way back to run.

While the controller clock is frozen, two restrictions apply:

- Only a parameterised whitelist of controller registers stays reachable. By default these are indices 0 to 5: general control, device control, device interrupt flags, device interrupt enables, buffer-memory address and buffer-memory data.
- The wakeup flag is the only interrupt source that can fire.

Accesses to registers outside the whitelist read as zero and lose their write. Each such access also pulses an error strobe.

Top module: `usb_clkfrz_ctrl`

## Requirements
- R1: While reset is held, and until two rising edges after it is released, the outputs are as follows: cpu_clk_en=1, osc_run=1, ctl_clk_en=0, wk_flag=0, cpu_wake=0 and acc_err=0. Reset is applied asynchronously and released synchronously.
- R2: ctl_clk_en equals (not frz_bit) and (not in power-down). It is updated only on the falling clock edge, so it changes only while clk is low. It is visible before the next rising edge.
- R3: slp_req=2'b01 in run enters idle at the next rising edge. In idle, cpu_clk_en=0, while osc_run and the controller clock enable are unaffected.
- R4: In idle, usb_irq raises cpu_wake in the same cycle, and the state returns to run at the next rising edge. usb_irq is raised by any irq_src bit, or by wk_flag with wk_ie set.
- R5: slp_req=2'b10 in run enters power-down at the next rising edge. In power-down, cpu_clk_en=0, ctl_clk_en=0 and osc_run=0, except that captured bus activity forces osc_run to 1.
- R6: In power-down, irq_src is ignored. The state leaves power-down only when wk_flag and wk_ie are both 1, and cpu_wake is asserted in that cycle.
- R7: A rise of bus_act sets the capture flop at once, even for a pulse shorter than a clock. wk_flag becomes 1 after the third rising edge that follows. The capture flop clears once the synchronizer output is 1 and bus_act is low.
- R8: wk_flag is sticky. It is cleared by wk_clr=1 at a rising edge, but a simultaneous set from the synchronizer wins.
- R9: While frz_bit=1, usb_irq equals wk_flag and wk_ie, and irq_src has no effect.
- R10: acc_mask is all ones while frz_bit=0, and equals the whitelist (default 16'h003F) while frz_bit=1.
- R11: An access (reg_rd or reg_wr) to an index whose acc_mask bit is 0 behaves as follows. rd_data_o is 0 and reg_wr_en is 0. acc_err is 1 for exactly the cycle after the access. Allowed accesses pass rd_data_i and reg_wr through.
- R12: slp_req codes 2'b00 and 2'b11 cause no sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_bit | input | 1 | Firmware freeze-clock control bit |
| slp_req | input | 2 | Sleep request: 01 idle, 10 power-down, others none |
| bus_act | input | 1 | Asynchronous USB bus activity |
| wk_ie | input | 1 | Wakeup interrupt enable |
| wk_clr | input | 1 | Write-1-to-clear strobe for the wakeup flag |
| irq_src | input | NIRQ | Enabled controller interrupt requests |
| reg_sel | input | log2(NREG) | Register index of the current access |
| reg_rd | input | 1 | Read access strobe |
| reg_wr | input | 1 | Write access strobe |
| rd_data_i | input | DW | Read data from the register file |
| ctl_clk_en | output | 1 | Glitch-free controller clock enable |
| osc_run | output | 1 | Oscillator run enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_wake | output | 1 | CPU wake request |
| usb_irq | output | 1 | Controller interrupt line after freeze masking |
| wk_flag | output | 1 | Sticky wakeup flag |
| acc_mask | output | NREG | Register-access permission mask |
| reg_wr_en | output | 1 | Write enable passed to the register file |
| rd_data_o | output | DW | Read data, zeroed for blocked accesses |
| acc_err | output | 1 | One-cycle strobe for a blocked access |

## Verification
The bench drives several distinct patterns, and each one separates a different part of the design:

- **Freeze toggling while running** shows that the controller enable follows the bit on the falling edge and leaves the CPU clock alone.
- **Idle entry with an ordinary interrupt** separates idle from power-down. The same interrupt line is later applied during power-down and during freeze, where it must not wake.
- **Bus activity, as a level and as a sub-cycle pulse**, checks the asynchronous capture, the three-edge flag latency, the early oscillator restart and the dependence on the enable.
- **Sweeping all register indices with freeze off and then on** separates the whitelist from the open mask, covering read zeroing, write blocking and the delayed error strobe.

// File: rtl/usbfz_pkg.sv
package usbfz_pkg;

  typedef enum logic [1:0] {
    PW_RUN  = 2'b00,
    PW_IDLE = 2'b01,
    PW_DOWN = 2'b10
  } pw_state_e;

  localparam logic [1:0] SLP_IDLE = 2'b01;
  localparam logic [1:0] SLP_DOWN = 2'b10;

endpackage

// File: rtl/usbfz_wake_sync.sv
module usbfz_wake_sync (
  input  logic clk,
  input  logic rst_ni,
  input  logic bus_act,
  input  logic wk_clr,
  output logic flag_o,
  output logic cap_o
);

  logic cap_q;
  logic cap_clr;
  logic sync1_q, sync2_q;
  logic flag_q, flag_d;

  // Capture clears only after the event has reached the synchronizer output.
  assign cap_clr = sync2_q & ~bus_act;

  // Asynchronous set: activity is held even when no clock edge arrives.
  always_ff @(posedge clk or negedge rst_ni or posedge bus_act) begin
    if (!rst_ni)      cap_q <= 1'b0;
    else if (bus_act) cap_q <= 1'b1;
    else if (cap_clr) cap_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= cap_q;
      sync2_q <= sync1_q;
    end
  end

  // Set has priority over write-1-to-clear.
  always_comb begin
    flag_d = flag_q;
    if (wk_clr) flag_d = 1'b0;
    if (sync2_q) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign cap_o  = cap_q;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !wk_clr) |=> flag_q);

  // R7
  sync_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sync2_q |=> flag_q);

endmodule

// File: rtl/usbfz_pwr_fsm.sv
module usbfz_pwr_fsm
  import usbfz_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [1:0]      slp_req,
  input  logic            frz,
  input  logic [NIRQ-1:0] irq_src,
  input  logic            wk_flag,
  input  logic            wk_ie,
  input  logic            cap,
  output pw_state_e       state_o,
  output logic            cpu_clk_en,
  output logic            osc_run,
  output logic            cpu_wake,
  output logic            usb_irq
);

  pw_state_e state_q, state_d;
  logic      wake_c;

  assign wake_c  = wk_flag & wk_ie;
  // While frozen, only the wakeup source reaches the line.
  assign usb_irq = wake_c | (~frz & (|irq_src));

  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_RUN: begin
        if (slp_req == SLP_IDLE)      state_d = PW_IDLE;
        else if (slp_req == SLP_DOWN) state_d = PW_DOWN;
      end
      PW_IDLE: if (usb_irq) state_d = PW_RUN;
      PW_DOWN: if (wake_c)  state_d = PW_RUN;
      default: state_d = PW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= PW_RUN;
    else         state_q <= state_d;
  end

  always_comb begin
    cpu_wake = 1'b0;
    if (state_q == PW_IDLE) cpu_wake = usb_irq;
    if (state_q == PW_DOWN) cpu_wake = wake_c;
  end

  assign cpu_clk_en = (state_q == PW_RUN);
  assign osc_run    = (state_q != PW_DOWN) | cap;
  assign state_o    = state_q;

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PW_IDLE && usb_irq) |=> state_q == PW_RUN);

  // R6
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PW_DOWN && !(wk_flag && wk_ie)) |=> state_q == PW_DOWN);

  // R9
  frozen_irq_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (frz && !wk_flag) |-> !usb_irq);

  // R12
  no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PW_RUN && (slp_req == 2'b00 || slp_req == 2'b11)) |=> state_q == PW_RUN);

endmodule

// File: rtl/usbfz_acc_filt.sv
module usbfz_acc_filt #(
  parameter int              NREG    = 16,
  parameter int              DW      = 8,
  parameter logic [NREG-1:0] WL_MASK = NREG'(6'h3F),
  localparam int             AW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            frz,
  input  logic [AW-1:0]   reg_sel,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [DW-1:0]   rd_data_i,
  output logic [NREG-1:0] acc_mask,
  output logic            reg_wr_en,
  output logic [DW-1:0]   rd_data_o,
  output logic            acc_err
);

  logic hit;
  logic req;
  logic err_d, err_q;

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    assign acc_mask[g] = ~frz | WL_MASK[g];
  end

  assign hit       = acc_mask[reg_sel];
  assign req       = reg_rd | reg_wr;
  assign reg_wr_en = reg_wr & hit;
  assign rd_data_o = hit ? rd_data_i : '0;
  assign err_d     = req & ~hit;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign acc_err = err_q;

  // R11
  outside_err_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (frz && (reg_rd || reg_wr) && !WL_MASK[reg_sel]) |=> acc_err);

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!frz) |=> !acc_err);

  // R10
  open_mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!frz) |-> (&acc_mask));

endmodule

// File: rtl/usbfz_clk_en.sv
module usbfz_clk_en (
  input  logic clk,
  input  logic rst_ni,
  input  logic run_req,
  output logic clk_en_o
);

  logic en_q;

  // Falling-edge update: the enable settles while clk is low.
  always_ff @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_req;
  end

  assign clk_en_o = en_q;

endmodule

// File: rtl/usb_clkfrz_ctrl.sv
module usb_clkfrz_ctrl
  import usbfz_pkg::*;
#(
  parameter int              NIRQ    = 4,
  parameter int              NREG    = 16,
  parameter int              DW      = 8,
  parameter logic [NREG-1:0] WL_MASK = NREG'(6'h3F)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frz_bit,
  input  logic [1:0]               slp_req,
  input  logic                     bus_act,
  input  logic                     wk_ie,
  input  logic                     wk_clr,
  input  logic [NIRQ-1:0]          irq_src,
  input  logic [$clog2(NREG)-1:0]  reg_sel,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [DW-1:0]            rd_data_i,
  output logic                     ctl_clk_en,
  output logic                     osc_run,
  output logic                     cpu_clk_en,
  output logic                     cpu_wake,
  output logic                     usb_irq,
  output logic                     wk_flag,
  output logic [NREG-1:0]          acc_mask,
  output logic                     reg_wr_en,
  output logic [DW-1:0]            rd_data_o,
  output logic                     acc_err
);

  logic      rs1_q, rs2_q, rst_ni;
  logic      cap;
  logic      run_req;
  pw_state_e state;

  // Reset: asserted asynchronously, released on the second rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  usbfz_wake_sync u_wake (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .bus_act (bus_act),
    .wk_clr  (wk_clr),
    .flag_o  (wk_flag),
    .cap_o   (cap)
  );

  usbfz_pwr_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .slp_req    (slp_req),
    .frz        (frz_bit),
    .irq_src    (irq_src),
    .wk_flag    (wk_flag),
    .wk_ie      (wk_ie),
    .cap        (cap),
    .state_o    (state),
    .cpu_clk_en (cpu_clk_en),
    .osc_run    (osc_run),
    .cpu_wake   (cpu_wake),
    .usb_irq    (usb_irq)
  );

  assign run_req = ~frz_bit & (state != PW_DOWN);

  usbfz_clk_en u_cen (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .run_req  (run_req),
    .clk_en_o (ctl_clk_en)
  );

  usbfz_acc_filt #(.NREG(NREG), .DW(DW), .WL_MASK(WL_MASK)) u_acc (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .frz       (frz_bit),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .rd_data_i (rd_data_i),
    .acc_mask  (acc_mask),
    .reg_wr_en (reg_wr_en),
    .rd_data_o (rd_data_o),
    .acc_err   (acc_err)
  );

  // R2
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    frz_bit |-> !ctl_clk_en);

  // R5
  ctl_pd_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == PW_DOWN) |-> (!ctl_clk_en && !cpu_clk_en));

endmodule

// File: tb/sim_usb_clkfrz_ctrl.sv
`timescale 1ns/100ps
module sim_usb_clkfrz_ctrl;

  localparam int          NIRQ = 4;
  localparam int          NREG = 16;
  localparam int          DW   = 8;
  localparam logic [15:0] WL   = 16'h003F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic frz_bit;
  logic [1:0] slp_req;
  logic bus_act;
  logic wk_ie;
  logic wk_clr;
  logic [NIRQ-1:0] irq_src;
  logic [3:0] reg_sel;
  logic reg_rd;
  logic reg_wr;
  logic [DW-1:0] rd_data_i;
  logic ctl_clk_en, osc_run, cpu_clk_en, cpu_wake, usb_irq, wk_flag;
  logic [NREG-1:0] acc_mask;
  logic reg_wr_en;
  logic [DW-1:0] rd_data_o;
  logic acc_err;

  usb_clkfrz_ctrl #(.NIRQ(NIRQ), .NREG(NREG), .DW(DW), .WL_MASK(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .frz_bit(frz_bit), .slp_req(slp_req),
    .bus_act(bus_act), .wk_ie(wk_ie), .wk_clr(wk_clr), .irq_src(irq_src),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .rd_data_i(rd_data_i),
    .ctl_clk_en(ctl_clk_en), .osc_run(osc_run), .cpu_clk_en(cpu_clk_en),
    .cpu_wake(cpu_wake), .usb_irq(usb_irq), .wk_flag(wk_flag),
    .acc_mask(acc_mask), .reg_wr_en(reg_wr_en), .rd_data_o(rd_data_o),
    .acc_err(acc_err)
  );

  // Behavioural reference: 0 run, 1 idle, 2 power-down.
  int    ms = 0;
  bit    flag_m = 0, cap_m = 0, s1_m = 0, s2_m = 0, err_m = 0;
  int    rcnt = 0;
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string phase = "R1 reset";

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, phase, nm, act, exp);
    end
  endtask

  task automatic cyc();
    bit rel, wake_c, irq_e, ok, new_cap;
    logic [15:0] mask;
    #3;
    rel    = (rcnt >= 2);
    wake_c = flag_m && wk_ie;
    irq_e  = wake_c || (!frz_bit && (irq_src != 0));
    mask   = frz_bit ? WL : 16'hFFFF;
    ok     = mask[reg_sel];
    chk("R2",  "ctl_clk_en", 32'(ctl_clk_en), 32'(rel && !frz_bit && ms != 2));
    chk("R5",  "osc_run",    32'(osc_run),    32'(ms != 2 || cap_m));
    chk("R3",  "cpu_clk_en", 32'(cpu_clk_en), 32'(ms == 0));
    chk("R4",  "cpu_wake",   32'(cpu_wake),   32'((ms == 1 && irq_e) || (ms == 2 && wake_c)));
    chk("R9",  "usb_irq",    32'(usb_irq),    32'(irq_e));
    chk("R7",  "wk_flag",    32'(wk_flag),    32'(flag_m));
    chk("R10", "acc_mask",   32'(acc_mask),   32'(mask));
    chk("R11", "reg_wr_en",  32'(reg_wr_en),  32'(reg_wr && ok));
    chk("R11", "rd_data_o",  32'(rd_data_o),  ok ? 32'(rd_data_i) : 32'd0);
    chk("R11", "acc_err",    32'(acc_err),    32'(err_m));
    if (!rel) begin
      ms = 0; flag_m = 0; cap_m = 0; s1_m = 0; s2_m = 0; err_m = 0;
    end else begin
      case (ms)
        0: if (slp_req == 2'b01) ms = 1; else if (slp_req == 2'b10) ms = 2;
        1: if (irq_e)  ms = 0;
        2: if (wake_c) ms = 0;
        default: ms = 0;
      endcase
      flag_m  = s2_m || (flag_m && !wk_clr);
      new_cap = bus_act ? 1'b1 : (s2_m ? 1'b0 : cap_m);
      s2_m    = s1_m;
      s1_m    = cap_m;
      cap_m   = new_cap;
      err_m   = (reg_rd || reg_wr) && !ok;
    end
    rcnt = rst_n ? ((rcnt < 2) ? rcnt + 1 : 2) : 0;
    @(posedge clk);
    #0.5;
  endtask

  task automatic set_bus(logic v);
    bus_act = v;
    if (v && rcnt >= 2) cap_m = 1;
  endtask

  task automatic short_pulse();
    bus_act = 1'b1;
    if (rcnt >= 2) cap_m = 1;
    #0.3;
    bus_act = 1'b0;
    cyc();
  endtask

  task automatic clear_flag();
    wk_clr = 1'b1; cyc(); wk_clr = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frz_bit = 0; slp_req = 0; bus_act = 0; wk_ie = 0; wk_clr = 0;
    irq_src = '0; reg_sel = '0; reg_rd = 0; reg_wr = 0; rd_data_i = 8'h5A;
    @(posedge clk); #0.5;
    // R1: reset state and synchronous release
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R2: freeze gates controller enable on falling edge
    phase = "R2 freeze";
    frz_bit = 1; repeat (3) cyc();
    frz_bit = 0; repeat (2) cyc();

    // R3/R4: idle entry, ordinary interrupt wakes
    phase = "R3 idle";
    slp_req = 2'b01; cyc(); slp_req = 2'b00; repeat (3) cyc();
    phase = "R4 idle-wake";
    irq_src = 4'b0010; repeat (2) cyc(); irq_src = '0; cyc();

    // R9: frozen idle ignores irq_src, wakes on flag
    phase = "R9 frozen";
    frz_bit = 1; slp_req = 2'b01; cyc(); slp_req = 2'b00;
    irq_src = 4'b1001; repeat (3) cyc();
    wk_ie = 1; short_pulse(); repeat (5) cyc();
    irq_src = '0; clear_flag(); frz_bit = 0; repeat (2) cyc();

    // R12: codes 00 and 11 never sleep
    phase = "R12 no-sleep";
    slp_req = 2'b11; repeat (3) cyc(); slp_req = 2'b00; repeat (2) cyc();

    // R5/R6: power-down ignores irq_src, wakes only via flag
    phase = "R5 pd";
    slp_req = 2'b10; cyc(); slp_req = 2'b00;
    irq_src = 4'b0001; repeat (4) cyc(); irq_src = '0;
    phase = "R6 pd-wake";
    set_bus(1); repeat (2) cyc(); set_bus(0); repeat (5) cyc();
    clear_flag(); repeat (2) cyc();

    // R7/R8: activity with enable off, late enable, sticky flag
    phase = "R7 pd-noie";
    wk_ie = 0; slp_req = 2'b10; cyc(); slp_req = 2'b00; repeat (2) cyc();
    short_pulse(); repeat (6) cyc();
    phase = "R8 sticky";
    wk_ie = 1; repeat (2) cyc();
    clear_flag(); repeat (2) cyc();
    set_bus(1); repeat (4) cyc();
    wk_clr = 1; repeat (2) cyc(); wk_clr = 0;
    set_bus(0); repeat (4) cyc();
    clear_flag(); repeat (2) cyc();
    wk_ie = 0;

    // R10/R11: register sweep, open then frozen
    for (int f = 0; f < 2; f++) begin
      phase = (f == 0) ? "R10 open" : "R11 frozen-acc";
      frz_bit = f[0];
      for (int s = 0; s < 16; s++) begin
        reg_sel   = s[3:0];
        reg_rd    = s[0];
        reg_wr    = !s[0];
        rd_data_i = 8'(s * 17 + 3);
        cyc();
      end
      reg_rd = 0; reg_wr = 0; cyc();
    end
    frz_bit = 0; repeat (2) cyc();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule